// File: doc/BRIEF.md
# Interrupt Vector Table and Message Dispatcher

This block keeps a table of per-vector message descriptors and a pending-bit array inside one 4 KB register page, and turns interrupt requests from a device into message writes. A 32-bit register port reads and writes the page. Each table entry is 16 bytes long. Its first word is the low half of the message address, then the high half, then the message data word, then a control word whose bit 0 masks the vector. The pending bits sit from page offset 0x800 upward and are read-only from the register port.

An interrupt request names a vector and a level, and uses a valid/ready handshake. If the level is high and the vector is allowed, the block issues a message on a valid/ready output. If the vector is blocked, the block records the vector in the pending array instead. A vector is blocked when the function is disabled, when the function mask is set, or when the vector's own mask bit is set. Pending vectors are looked at again in two cases: after any table write to their entry, and after a rescan strobe from the capability logic. The rescan sweeps every vector in ascending order. A blocked interrupt is therefore delivered late and never dropped.

Back-pressure rules: only one message is held on the output at a time. Once `msg_valid` rises, the address and data stay fixed until a cycle in which `msg_ready` is high. While a message is held, `irq_ready` is low, and the table checks that follow writes and rescans wait.

Top module: `msgvec_dispatch`

## Requirements
- R1: After reset, all table words and all pending bits are zero, `msg_valid` is low, `irq_ready` is high, and every register read returns zero.
- R2: A register write with all four byte enables set (`bus_be` = 4'hF) stores the word in entry `addr[10:4]`, word `addr[3:2]` (0 address low, 1 address high, 2 data, 3 control). A write with any byte enable clear is dropped. `addr[1:0]` is ignored. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R3: Writes at offset 0x800 or above change nothing. A read at 0x800 + 4·w returns the pending bits of vectors 32·w to 32·w+31, with vector i at bit i mod 32. Bits for vectors at or above `NUM_VEC` read as zero.
- R4: Entries at or above `NUM_VEC` read as zero and ignore writes. An interrupt request with an index at or above `NUM_VEC` is accepted and has no effect.
- R5: An accepted request with `irq_level` low issues no message and changes no pending bit.
- R6: An accepted high-level request for a blocked vector sets that vector's pending bit and issues no message. Blocked means `fn_enable` is low, `fn_mask` is high, or control bit 0 of the entry is set.
- R7: An accepted high-level request for an unblocked vector clears its pending bit and issues one message. The address is {address high, address low with bits 1:0 forced to zero} and the data is the entry's data word.
- R8: After a full-word write to any word of entry e, the block checks e. If e is pending and unblocked, the block clears the pending bit and issues e's message using the entry contents as they are after the write.
- R9: A one-cycle `rescan` pulse checks vectors 0 to `NUM_VEC`−1 in ascending order. Each one that is pending and unblocked is issued, so the messages leave in ascending vector order.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold their values. `irq_ready` is low whenever a message is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset within the page |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables; only 4'hF writes |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| fn_enable | input | 1 | Function-level interrupt enable |
| fn_mask | input | 1 | Function-level mask |
| rescan | input | 1 | Pulse: sweep all pending vectors |
| irq_valid | input | 1 | Interrupt request valid |
| irq_ready | output | 1 | Interrupt request accepted when high with valid |
| irq_idx | input | 7 | Vector index of the request |
| irq_level | input | 1 | Request level; only high acts |
| msg_valid | output | 1 | Message write valid |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
A wrong pending bit shows at the ports in two ways. A bit that should be set but is not loses an interrupt: the message is missing after the unmasking write or the rescan. A bit that is stuck set produces an extra message after the next write to that entry. Either fault also shows within one cycle on a read of the pending words. A wrong check order or a lost check request shows as messages that leave out of ascending order, or that never leave, during a rescan. A wrong table word shows in the address or data of the next message from that vector, and on read-back one cycle after the read strobe.

// File: rtl/msgvec_pkg.sv
package msgvec_pkg;
  localparam int IDX_W = 7;
  localparam int MAX_VEC = 128;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_CTRL    = 2'd3
  } word_e;

  typedef struct packed {
    logic [31:0] lo;
    logic [31:0] hi;
    logic [31:0] data;
    logic [31:0] ctrl;
  } entry_t;
endpackage

// File: rtl/msgvec_table.sv
module msgvec_table
  import msgvec_pkg::*;
#(
  parameter int NUM_VEC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic [3:0]         bus_be,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_VEC-1:0] pend,
  output logic               wr_hit,
  output logic [IDX_W-1:0]   wr_idx,
  input  logic [IDX_W-1:0]   lk_idx,
  output entry_t             lk_ent
);
  localparam int PEND_WORDS = (NUM_VEC + 31) / 32;
  localparam logic [IDX_W:0] NV = (IDX_W+1)'(NUM_VEC);

  entry_t [NUM_VEC-1:0] tab_q;
  logic [IDX_W-1:0] ent;
  word_e wsel;
  logic [8:0] pidx;
  logic in_range, wr_ok;
  logic [PEND_WORDS*32-1:0] pend_pad;
  logic [31:0] rd_word;
  logic unused_addr;

  assign ent = bus_addr[10:4];
  assign wsel = word_e'(bus_addr[3:2]);
  assign pidx = bus_addr[10:2];
  assign unused_addr = ^bus_addr[1:0];
  assign in_range = ({1'b0, ent} < NV);
  assign wr_ok = bus_wr && (bus_be == 4'hF) && !bus_addr[11] && in_range;
  assign wr_hit = wr_ok;
  assign wr_idx = ent;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tab_q[g] <= '0;
      end else if (wr_ok && ent == IDX_W'(g)) begin
        case (wsel)
          W_ADDR_LO: tab_q[g].lo   <= bus_wdata;
          W_ADDR_HI: tab_q[g].hi   <= bus_wdata;
          W_DATA:    tab_q[g].data <= bus_wdata;
          default:   tab_q[g].ctrl <= bus_wdata;
        endcase
      end
    end
  end

  always_comb begin
    lk_ent = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (lk_idx == IDX_W'(i)) lk_ent = tab_q[i];
    end
  end

  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_VEC-1:0] = pend;
  end

  always_comb begin
    rd_word = '0;
    if (bus_addr[11]) begin
      for (int w = 0; w < PEND_WORDS; w++) begin
        if (pidx == 9'(w)) rd_word = pend_pad[w*32 +: 32];
      end
    end else begin
      for (int i = 0; i < NUM_VEC; i++) begin
        if (ent == IDX_W'(i)) begin
          case (wsel)
            W_ADDR_LO: rd_word = tab_q[i].lo;
            W_ADDR_HI: rd_word = tab_q[i].hi;
            W_DATA:    rd_word = tab_q[i].data;
            default:   rd_word = tab_q[i].ctrl;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  AST_PBA_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[11]) |=> $stable(tab_q)); // R3
endmodule

// File: rtl/msgvec_pending.sv
module msgvec_pending
  import msgvec_pkg::*;
#(
  parameter int NUM_VEC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   idx,
  output logic [NUM_VEC-1:0] pend_q
);
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else if (idx == IDX_W'(g)) begin
        if (set_en) pend_q[g] <= 1'b1;
        else if (clr_en) pend_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/msgvec_engine.sv
module msgvec_engine
  import msgvec_pkg::*;
#(
  parameter int NUM_VEC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fn_enable,
  input  logic               fn_mask,
  input  logic               rescan,
  input  logic               irq_valid,
  output logic               irq_ready,
  input  logic [IDX_W-1:0]   irq_idx,
  input  logic               irq_level,
  input  logic               wr_hit,
  input  logic [IDX_W-1:0]   wr_idx,
  output logic [IDX_W-1:0]   lk_idx,
  input  entry_t             lk_ent,
  input  logic [NUM_VEC-1:0] pend,
  output logic               pnd_set,
  output logic               pnd_clr,
  output logic [IDX_W-1:0]   pnd_idx,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  localparam logic [IDX_W:0] NV = (IDX_W+1)'(NUM_VEC);

  logic [NUM_VEC-1:0] chk_q, chk_d;
  logic free, irq_fire, irq_inr, chk_fire, pick_any, blocked, pend_sel, load;
  logic [IDX_W-1:0] pick_idx, sel_idx;
  logic unused_bits;

  assign unused_bits = ^{lk_ent.ctrl[31:1], lk_ent.lo[1:0]};
  assign free = !msg_valid;
  assign irq_ready = free;
  assign irq_fire = irq_valid && free;
  assign irq_inr = ({1'b0, irq_idx} < NV);

  always_comb begin
    pick_any = 1'b0;
    pick_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (chk_q[i]) begin
        pick_any = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end

  assign chk_fire = free && !irq_valid && pick_any;
  assign sel_idx = irq_fire ? irq_idx : pick_idx;
  assign lk_idx = sel_idx;
  assign blocked = !fn_enable || fn_mask || lk_ent.ctrl[0];

  always_comb begin
    pend_sel = 1'b0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (sel_idx == IDX_W'(i)) pend_sel = pend[i];
    end
  end

  assign pnd_idx = sel_idx;
  assign pnd_set = irq_fire && irq_level && irq_inr && blocked;
  assign load = (irq_fire && irq_level && irq_inr && !blocked) ||
                (chk_fire && pend_sel && !blocked);
  assign pnd_clr = load;

  always_comb begin
    chk_d = chk_q;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (chk_fire && pick_idx == IDX_W'(i)) chk_d[i] = 1'b0;
      if (wr_hit && wr_idx == IDX_W'(i)) chk_d[i] = 1'b1;
    end
    if (rescan) chk_d = '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_q     <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      chk_q <= chk_d;
      if (load) begin
        msg_valid <= 1'b1;
        msg_addr  <= {lk_ent.hi, lk_ent.lo[31:2], 2'b00};
        msg_data  <= lk_ent.data;
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R10
endmodule

// File: rtl/msgvec_dispatch.sv
module msgvec_dispatch
  import msgvec_pkg::*;
#(
  parameter int NUM_VEC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_be,
  output logic [31:0] bus_rdata,
  input  logic        fn_enable,
  input  logic        fn_mask,
  input  logic        rescan,
  input  logic        irq_valid,
  output logic        irq_ready,
  input  logic [6:0]  irq_idx,
  input  logic        irq_level,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data
);
  logic [NUM_VEC-1:0] pend_w;
  logic wr_hit, pnd_set, pnd_clr;
  logic [IDX_W-1:0] wr_idx, lk_idx, pnd_idx;
  entry_t lk_ent;

  msgvec_table #(.NUM_VEC(NUM_VEC)) u_table (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .pend(pend_w), .wr_hit(wr_hit), .wr_idx(wr_idx),
    .lk_idx(lk_idx), .lk_ent(lk_ent)
  );

  msgvec_pending #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_en(pnd_set), .clr_en(pnd_clr),
    .idx(pnd_idx), .pend_q(pend_w)
  );

  msgvec_engine #(.NUM_VEC(NUM_VEC)) u_engine (
    .clk(clk), .rst_n(rst_n), .fn_enable(fn_enable), .fn_mask(fn_mask),
    .rescan(rescan), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_idx(irq_idx), .irq_level(irq_level), .wr_hit(wr_hit), .wr_idx(wr_idx),
    .lk_idx(lk_idx), .lk_ent(lk_ent), .pend(pend_w), .pnd_set(pnd_set),
    .pnd_clr(pnd_clr), .pnd_idx(pnd_idx), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  AST_LOW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && !irq_level) |=> (!msg_valid && $stable(pend_w))); // R5

  AST_MASKED_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    pnd_set |=> ((pend_w != '0) && !msg_valid)); // R6

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> !irq_ready); // R10
endmodule

// File: tb/sim_msgvec_dispatch.sv
module sim_msgvec_dispatch;
  localparam int NV = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0] bus_be = 4'hF;
  logic fn_enable = 1'b1, fn_mask = 1'b0, rescan = 1'b0;
  logic irq_valid = 0, irq_ready, irq_level = 0;
  logic [6:0] irq_idx = '0;
  logic msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0, fails = 0, cyc = 0;
  bit rand_rdy = 0;
  logic [31:0] m_lo[NV], m_hi[NV], m_data[NV], m_ctrl[NV];
  bit m_pend[NV];
  logic [95:0] exp_q[$], got_q[$];
  bit held_v = 0;
  logic [63:0] h_a;
  logic [31:0] h_d;

  always #10 clk = ~clk;

  msgvec_dispatch #(.NUM_VEC(NV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .fn_enable(fn_enable), .fn_mask(fn_mask), .rescan(rescan),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_idx(irq_idx), .irq_level(irq_level),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] fn_exp(input int v);
    return {m_hi[v], m_lo[v] & 32'hFFFF_FFFC, m_data[v]};
  endfunction

  function automatic bit is_blocked(input int v);
    return !fn_enable || fn_mask || m_ctrl[v][0];
  endfunction

  always @(posedge clk) begin
    #2;
    msg_ready = rand_rdy ? 1'($urandom % 2) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (held_v) begin
        checks++;
        if (!(msg_valid && msg_addr == h_a && msg_data == h_d)) begin
          fails++;
          $display("FAIL R10: actual %0h/%0h expected %0h/%0h", msg_addr, msg_data, h_a, h_d);
        end
      end
      held_v = msg_valid && !msg_ready;
      h_a = msg_addr;
      h_d = msg_data;
      if (msg_valid && msg_ready) got_q.push_back({msg_addr, msg_data});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    int v;
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 0; bus_be = 4'hF;
    v = int'(a[10:4]);
    if (be == 4'hF && !a[11] && v < NV) begin
      case (a[3:2])
        2'd0: m_lo[v] = d;
        2'd1: m_hi[v] = d;
        2'd2: m_data[v] = d;
        default: m_ctrl[v] = d;
      endcase
      if (m_pend[v] && !is_blocked(v)) begin
        m_pend[v] = 0;
        exp_q.push_back(fn_exp(v));
      end
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic irq(input int v, input bit lvl);
    @(negedge clk);
    irq_valid = 1; irq_idx = 7'(v); irq_level = lvl;
    while (!irq_ready) @(negedge clk);
    if (lvl && v < NV) begin
      if (is_blocked(v)) m_pend[v] = 1;
      else begin
        m_pend[v] = 0;
        exp_q.push_back(fn_exp(v));
      end
    end
    @(negedge clk);
    irq_valid = 0;
  endtask

  task automatic drain_cmp(input string req);
    repeat (40) @(negedge clk);
    check(got_q.size() == exp_q.size(), req, 96'(got_q.size()), 96'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic cmp_pend(input string req);
    logic [31:0] d, e;
    for (int w = 0; w < 2; w++) begin
      e = '0;
      for (int i = 0; i < NV; i++) if (i / 32 == w) e[i % 32] = m_pend[i];
      rd(12'h800 + 12'(4 * w), d);
      check(d == e, req, 96'(d), 96'(e));
    end
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    for (int i = 0; i < NV; i++) begin
      m_lo[i] = 0; m_hi[i] = 0; m_data[i] = 0; m_ctrl[i] = 0; m_pend[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(!msg_valid, "R1", 96'(msg_valid), 0);
    check(irq_ready, "R1 R10", 96'(irq_ready), 1);
    rd(12'h034, d); check(d == 0, "R1", 96'(d), 0);
    cmp_pend("R1");

    // R2: full-word write, partial write dropped, low address bits ignored
    wr(12'h030, 32'h1234_5678, 4'hF);
    rd(12'h030, d); check(d == 32'h1234_5678, "R2", 96'(d), 96'h1234_5678);
    wr(12'h038, 32'hAAAA_0001, 4'hF);
    wr(12'h038, 32'hDEAD_BEEF, 4'b0111);
    rd(12'h038, d); check(d == 32'hAAAA_0001, "R2", 96'(d), 96'hAAAA_0001);
    wr(12'h03B, 32'h0BAD_F00D, 4'hF);
    rd(12'h038, d); check(d == 32'h0BAD_F00D, "R2", 96'(d), 96'h0BAD_F00D);

    // R3: pending region is read-only
    wr(12'h800, 32'hFFFF_FFFF, 4'hF);
    cmp_pend("R3");

    // R4: out-of-range entry and vector index
    wr(12'h190, 32'h5555_5555, 4'hF);
    rd(12'h190, d); check(d == 0, "R4", 96'(d), 0);
    irq(25, 1);
    drain_cmp("R4");

    // program every entry at random, some masked
    for (int v = 0; v < NV; v++) begin
      wr(12'(16 * v), $urandom | 32'h3, 4'hF);
      wr(12'(16 * v + 4), $urandom, 4'hF);
      wr(12'(16 * v + 8), $urandom, 4'hF);
      wr(12'(16 * v + 12), ($urandom & 32'hFFFF_FFFE) | 32'(($urandom % 3) == 0), 4'hF);
    end
    drain_cmp("R8");

    // R5: low level is ignored
    for (int v = 0; v < NV; v++) irq(v, 0);
    drain_cmp("R5");
    cmp_pend("R5");

    // R6 R7 R10: random stream under back-pressure
    rand_rdy = 1;
    for (int n = 0; n < 250; n++) irq(int'($urandom % 24), 1'(($urandom % 4) != 0));
    rand_rdy = 0;
    drain_cmp("R7 R6");
    cmp_pend("R6");

    // R8: unmask all in ascending order releases pending vectors
    for (int v = 0; v < NV; v++) wr(12'(16 * v + 12), 32'h0, 4'hF);
    drain_cmp("R8");
    cmp_pend("R8");

    // R8: data rewrite while masked, then unmask, uses new data
    wr(12'h04C, 32'h1, 4'hF);
    irq(4, 1);
    wr(12'h048, 32'hC0DE_0004, 4'hF);
    drain_cmp("R8 masked");
    cmp_pend("R6");
    wr(12'h04C, 32'h0, 4'hF);
    drain_cmp("R8 unmask");

    // R6 R9: function mask and disable, then rescan in ascending order
    @(negedge clk); fn_mask = 1;
    irq(11, 1); irq(5, 1); irq(2, 1);
    @(negedge clk); fn_mask = 0; fn_enable = 0;
    irq(7, 1); irq(19, 1);
    drain_cmp("R6 fn");
    cmp_pend("R6 fn");
    @(negedge clk); fn_enable = 1;
    for (int v = 0; v < NV; v++)
      if (m_pend[v] && !is_blocked(v)) begin
        m_pend[v] = 0;
        exp_q.push_back(fn_exp(v));
      end
    @(negedge clk); rescan = 1;
    @(negedge clk); rescan = 0;
    drain_cmp("R9");
    cmp_pend("R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule